// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block gives software control of up to five banks of 32 general-purpose pins through a small 32-bit register bus. Each bank holds a direction word and an output latch. The latch can be loaded whole, or changed one bit at a time through write-one-to-set and write-one-to-clear words, so firmware never has to read, modify and write it back. The block drives the pin levels and the per-pin output enables. It also samples the pad levels through a two-stage synchronizer so that software can read them.

Pin n lives in bank n/32 at bit n%32. A direction bit of 1 keeps the pin an input with its driver off, and a direction bit of 0 turns the driver on. The pad level can be read back whatever the direction, but only after the synchronizer delay. A read issued just after a level change may still return the earlier value. Edge-interrupt words share each bank's address window but belong to a neighbouring block, so here they read as zero.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every direction word reads 0xFFFFFFFF, every output latch reads zero, and pin_out and pin_oe are all zero.
- R2: Bank b starts at byte address 0x10 + 0x28*b. Its words at relative offsets 0x0, 0x4, 0x8, 0xC and 0x10 are, in that order, direction, output latch, set, clear and input level.
- R3: pin_oe for a pin is the inverse of its direction bit: 1 means input with the driver off, 0 means output with the driver on.
- R4: Writing the set word raises every latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: Writing the clear word lowers every latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: The output latch word can be written directly, and reading it returns the latch value.
- R7: The input-level word returns the synchronized pad level, also for pins set as outputs. After a pad change, a read issued at the first or second rising edge returns the old level, and a read issued at the third returns the new one.
- R8: pin_out[n] and pin_oe[n] come from bit n%32 of bank n/32.
- R9: These addresses read as zero: addresses outside the five windows, offsets 0x14 to 0x24 inside a window, misaligned addresses, and the write-only set and clear words. Writes to unmapped or misaligned addresses and writes to the input-level word change no state.
- R10: A read request gives rsp_valid high, with rsp_rdata, exactly one cycle later. rsp_valid stays low after cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and synchronizer |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | BANK_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | BANK_W | Read data |
| pin_in | input | NUM_BANKS*BANK_W | Pad input levels, asynchronous |
| pin_out | output | NUM_BANKS*BANK_W | Pin output values from the latches |
| pin_oe | output | NUM_BANKS*BANK_W | Per-pin output enable |

## Verification
Two events can fall in the same cycle: a pad level change and a read of the input-level word that covers it. The bench provokes this by changing the pad level of bank 0 in the same cycle it starts issuing back-to-back reads of that word, with the bank set to output. It then judges each response against the stale, stale, fresh sequence that R7 requires. Random traffic mixes set, clear, load and direction writes with reads, and a bench model compares every readback and the pin vectors.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned FIRST_BANK_BYTE   = 16;
  localparam int unsigned BANK_STRIDE_BYTES = 40;
  localparam int unsigned WORD_BYTES        = 4;
  localparam int unsigned LIVE_WORDS        = 5;

  typedef enum logic [3:0] {
    W_DIR = 4'd0,
    W_OUT = 4'd1,
    W_SET = 4'd2,
    W_CLR = 4'd3,
    W_IN  = 4'd4
  } gpio_word_e;

  function automatic int unsigned bank_base_byte(input int unsigned b);
    return FIRST_BANK_BYTE + BANK_STRIDE_BYTES * b;
  endfunction

  function automatic bit addr_in_bank(input int unsigned a, input int unsigned b);
    int unsigned lo;
    lo = bank_base_byte(b);
    return (a >= lo) && (a < lo + LIVE_WORDS * WORD_BYTES) && ((a % WORD_BYTES) == 0);
  endfunction

  function automatic gpio_word_e word_of(input int unsigned a, input int unsigned b);
    int unsigned rel;
    rel = (a - bank_base_byte(b)) / WORD_BYTES;
    return gpio_word_e'(rel[3:0]);
  endfunction

  function automatic int unsigned pin_bank(input int unsigned n, input int unsigned w);
    return n / w;
  endfunction

  function automatic int unsigned pin_bit(input int unsigned n, input int unsigned w);
    return n % w;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output gpio_word_e           word
);

  int unsigned addr_u;
  assign addr_u = 32'(addr);

  always_comb begin
    bank_hit = '0;
    word     = W_DIR;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (addr_in_bank(addr_u, b)) begin
        bank_hit[b] = 1'b1;
        word        = word_of(addr_u, b);
      end
    end
  end

  // R2: at most one bank window claims an address
  always_comb begin
    a_hit_onehot_r2: assert ($onehot0(bank_hit));
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  gpio_word_e        word,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] out_q
);

  logic dir_evt, load_evt, set_evt, clr_evt;
  assign dir_evt  = wr_en && (word == W_DIR);
  assign load_evt = wr_en && (word == W_OUT);
  assign set_evt  = wr_en && (word == W_SET);
  assign clr_evt  = wr_en && (word == W_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (dir_evt)  dir_q <= wdata;
      if (load_evt) out_q <= wdata;
      else if (set_evt) out_q <= out_q | wdata;
      else if (clr_evt) out_q <= out_q & ~wdata;
    end
  end

  p_set_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ((out_q & $past(wdata)) == $past(wdata)));

  p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

  p_clr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> ((out_q & $past(wdata)) == '0));

  p_clr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (out_q == $past(wdata)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
      warm_q   <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  // R7: two flops of delay from pad to readable value
  p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NPINS    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BANK_W-1:0] rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  logic [NUM_BANKS-1:0] bank_hit;
  gpio_word_e           word;
  logic [BANK_W-1:0]    dir_a [NUM_BANKS];
  logic [BANK_W-1:0]    out_a [NUM_BANKS];
  logic [NPINS-1:0]     in_sync;
  logic [BANK_W-1:0]    rd_word;
  logic                 rd_req, wr_req, any_hit;

  assign rd_req  = req_valid && !req_write;
  assign wr_req  = req_valid && req_write;
  assign any_hit = |bank_hit;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (req_addr),
    .bank_hit (bank_hit),
    .word     (word)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_regs #(.BANK_W(BANK_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_req && bank_hit[b]),
      .word  (word),
      .wdata (req_wdata),
      .dir_q (dir_a[b]),
      .out_q (out_a[b])
    );
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int unsigned PB = pin_bank(n, BANK_W);
    localparam int unsigned PN = pin_bit(n, BANK_W);
    assign pin_out[n] = out_a[PB][PN];
    assign pin_oe[n]  = ~dir_a[PB][PN];
  end

  gpio_in_sync #(.WIDTH(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  always_comb begin
    rd_word = '0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (word)
          W_DIR:   rd_word = dir_a[b];
          W_OUT:   rd_word = out_a[b];
          W_IN:    rd_word = in_sync[b*BANK_W +: BANK_W];
          default: rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_word : '0;
    end
  end

  p_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !any_hit) |=> (rsp_rdata == '0));

  p_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (req_addr == ADDR_W'(bank_base_byte(0))))
      |=> (pin_oe[BANK_W-1:0] == ~$past(req_wdata)));

endmodule

// File: tb/gpio_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_regfile_tb_top;

  localparam int NB = 5;
  localparam int BW = 32;
  localparam int AW = 8;
  localparam int NP = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_wdata;
  logic          rsp_valid;
  logic [BW-1:0] rsp_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  logic [BW-1:0] m_dir [NB];
  logic [BW-1:0] m_out [NB];

  always #2.5 clk = ~clk;

  gpio_bank_regfile #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [AW-1:0] waddr(input int b, input int w);
    return AW'('h10 + b * 'h28 + w * 4);
  endfunction

  function automatic logic [NP-1:0] exp_pins_out();
    logic [NP-1:0] v;
    for (int b = 0; b < NB; b++) v[b*BW +: BW] = m_out[b];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_pins_oe();
    logic [NP-1:0] v;
    for (int b = 0; b < NB; b++) v[b*BW +: BW] = ~m_dir[b];
    return v;
  endfunction

  function automatic logic [BW-1:0] exp_read(input int b, input int w);
    case (w)
      0: return m_dir[b];
      1: return m_out[b];
      4: return pin_in[b*BW +: BW];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic model_write(input int b, input int w, input logic [BW-1:0] d);
    case (w)
      0: m_dir[b] = d;
      1: m_out[b] = d;
      2: m_out[b] = m_out[b] | d;
      3: m_out[b] = m_out[b] & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [BW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    check("R10 rsp_valid after read", NP'(rsp_valid), NP'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] r;
    logic [BW-1:0] old_v, new_v;
    void'($urandom(32'h6A5C));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; pin_in = '0;
    for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_out reset", pin_out, '0);
    check("R1 pin_oe reset", pin_oe, '0);
    check("R10 idle rsp_valid", NP'(rsp_valid), '0);
    for (int b = 0; b < NB; b++) begin
      bus_read(waddr(b, 0), r); check("R1 R2 dir reset", NP'(r), NP'(32'hFFFF_FFFF));
      bus_read(waddr(b, 1), r); check("R1 R2 out reset", NP'(r), '0);
    end

    // R6 direct load and readback, R8 pin mapping
    for (int b = 0; b < NB; b++) begin
      automatic logic [BW-1:0] d = $urandom();
      bus_write(waddr(b, 1), d); model_write(b, 1, d);
      bus_read(waddr(b, 1), r); check("R6 latch readback", NP'(r), NP'(m_out[b]));
    end
    check("R8 pin_out after loads", pin_out, exp_pins_out());

    // R8 directed: single pin 101 is bank 3 bit 5
    for (int b = 0; b < NB; b++) begin bus_write(waddr(b, 1), '0); model_write(b, 1, '0); end
    bus_write(waddr(3, 2), 32'h20); model_write(3, 2, 32'h20);
    check("R8 R4 pin 101 alone", pin_out, NP'(1) << 101);

    // R4 / R5 directed
    bus_write(waddr(2, 1), 32'hF0F0_0F0F); model_write(2, 1, 32'hF0F0_0F0F);
    bus_write(waddr(2, 2), 32'h0000_00F0); model_write(2, 2, 32'h0000_00F0);
    bus_read(waddr(2, 1), r); check("R4 set keeps others", NP'(r), NP'(32'hF0F0_0FFF));
    bus_write(waddr(2, 3), 32'hF000_0001); model_write(2, 3, 32'hF000_0001);
    bus_read(waddr(2, 1), r); check("R5 clear keeps others", NP'(r), NP'(32'h00F0_0FFE));
    bus_write(waddr(2, 2), 32'h0); model_write(2, 2, 32'h0);
    bus_read(waddr(2, 1), r); check("R4 zero set no change", NP'(r), NP'(32'h00F0_0FFE));

    // R3 direction to output enable
    for (int b = 0; b < NB; b++) begin
      automatic logic [BW-1:0] d = $urandom();
      bus_write(waddr(b, 0), d); model_write(b, 0, d);
    end
    check("R3 pin_oe inverse of direction", pin_oe, exp_pins_oe());

    // R7 synchronizer latency, bank 0 driven as output
    bus_write(waddr(0, 0), '0); model_write(0, 0, '0);
    pin_in = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    repeat (3) @(negedge clk);
    old_v = pin_in[BW-1:0];
    new_v = ~old_v;
    pin_in[BW-1:0] = new_v;
    req_valid = 1'b1; req_write = 1'b0; req_addr = waddr(0, 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check($sformatf("R7 input read %0d after change", k), NP'(rsp_rdata),
            NP'((k < 2) ? old_v : new_v));
    end
    req_valid = 1'b0;

    // R9 unmapped, gaps, misaligned, write-only words
    begin
      automatic logic [AW-1:0] holes [7] = '{8'h00, 8'h0C, 8'h24, 8'h11, 8'h4A, 8'hD8, 8'hFC};
      for (int i = 0; i < 7; i++) begin
        bus_read(holes[i], r); check("R9 unmapped reads zero", NP'(r), '0);
        bus_write(holes[i], 32'hFFFF_FFFF);
      end
      bus_read(waddr(1, 2), r); check("R9 set word reads zero", NP'(r), '0);
      bus_read(waddr(4, 3), r); check("R9 clear word reads zero", NP'(r), '0);
      bus_write(waddr(1, 4), 32'hFFFF_FFFF);
      check("R9 stray writes leave pin_out", pin_out, exp_pins_out());
      check("R9 stray writes leave pin_oe", pin_oe, exp_pins_oe());
    end

    // random mix against model
    for (int i = 0; i < 400; i++) begin
      automatic int b = $urandom_range(NB - 1, 0);
      automatic int w = $urandom_range(4, 0);
      automatic logic [BW-1:0] d = $urandom();
      if ($urandom_range(1, 0) == 1) begin
        bus_write(waddr(b, w), d); model_write(b, w, d);
      end else begin
        bus_read(waddr(b, w), r);
        check($sformatf("R2 R4 R5 R6 random read bank %0d word %0d", b, w), NP'(r), NP'(exp_read(b, w)));
      end
    end
    check("R8 final pin_out", pin_out, exp_pins_out());
    check("R3 final pin_oe", pin_oe, exp_pins_oe());
    @(negedge clk);
    check("R10 no rsp without read", NP'(rsp_valid), '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule